// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the front end of a small 8-bit core. Program memory is addressed in bytes and holds 16-bit instruction words, so every word sits at an even byte address. The block holds a 21-bit byte program counter and streams word fetches out of a synchronous memory port. Each returning word is classified from its top four bits. A one-word instruction is reported at once. The first word of a two-word instruction is held back so that the low 12 bits of the following word can be attached to it as a literal.

The block handles control flow itself. An absolute jump carries a word address that is split across both of its words. A relative branch carries a signed count of words. A conditional skip drops exactly one following word when the core's condition input is high in the strobe cycle. A continuation word (top bits 1111) that arrives with no pending first word, for example after a skip removed its partner, is reported as a no-operation. The core reads a valid strobe, the first instruction word, the attached literal, the instruction's byte address and a kind code.

Top module: `wordpair_fetch`

## Requirements
- R1: While reset is held, `mem_addr` is 0 and `mem_en` and `ins_vld` are 0. The first word requested after reset is at byte address 0.
- R2: When no redirect occurs, `mem_addr` rises by 2 every cycle that `mem_en` is high. Bit 0 is always 0, and the address wraps modulo 2^21.
- R3: Memory returns a word one cycle after its address. A one-word instruction whose address A is on `mem_addr` in cycle t is reported with `ins_vld` in cycle t+1, with `ins_addr` = A.
- R4: A word with top bits 1100 starts a two-word data instruction. No strobe is given for the first word. In the cycle the next word arrives, one strobe is given with kind 1, `ins_word` = first word, `ins_lit` = low 12 bits of the second word and `ins_addr` = address of the first word.
- R5: A word with top bits 1111 that arrives with no pending first word is reported as a no-operation: kind 5, `ins_word` = that word, `ins_lit` = 0, with no effect on the PC.
- R6: A word with top bits 1110 starts a two-word absolute jump (kind 2). The new byte address is {first[7:0], second[11:0], 0}.
- R7: A word with top bits 1101 is a relative branch (kind 3). Bits 11:0 are a signed word count. The new address is (instruction address + 2 + 2 × count) modulo 2^21.
- R8: In the cycle after a jump or branch strobe, `ins_vld` is 0 and `mem_addr` equals the new address. Words fetched before the redirect are never reported.
- R9: A word with top bits 1011 is a conditional skip (kind 4). If `skip_cond` is 1 in its strobe cycle, the next word is dropped with no strobe and no effect, even if it is a branch. If the dropped word starts a two-word instruction, its second word is reported as in R5.
- R10: A word with any other top bits is a plain one-word instruction: kind 0, `ins_lit` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 21 | Byte address of the word being fetched |
| mem_en | output | 1 | Read request to program memory |
| mem_rdata | input | 16 | Word for the address requested in the previous cycle |
| skip_cond | input | 1 | Condition for a skip, sampled in the skip's strobe cycle |
| ins_vld | output | 1 | One strobe per completed instruction |
| ins_kind | output | 3 | 0 plain, 1 two-word data, 2 jump, 3 branch, 4 skip, 5 no-operation |
| ins_word | output | 16 | First word of the instruction |
| ins_lit | output | 12 | Literal from the second word, 0 for one-word kinds |
| ins_addr | output | 21 | Byte address of the instruction's first word |

## Verification
Every instruction result is due in the cycle after the last of its words was presented on `mem_addr`. One-word kinds therefore carry the previous cycle's address, and two-word kinds carry that address minus 2. After a jump or branch strobe, the next cycle must show a bubble with the new target already on `mem_addr`. The monitor samples at the falling edge and tracks the previous cycle's address. It pops one expected item per strobe and checks each field, the address latency and the bubble cycle that follows a redirect. The program includes a skip over a jump's first word, a skip over a branch, a backward branch, and a branch that wraps below address zero into a jump whose second word sits at address 0.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  localparam int PC_W   = 21;
  localparam int WORD_W = 16;
  localparam int LIT_W  = 12;
  localparam int TAG_W  = 4;
  localparam int JHI_W  = PC_W - 1 - LIT_W;

  localparam logic [TAG_W-1:0] TAG_CONT   = 4'hF;
  localparam logic [TAG_W-1:0] TAG_JUMP   = 4'hE;
  localparam logic [TAG_W-1:0] TAG_BRANCH = 4'hD;
  localparam logic [TAG_W-1:0] TAG_PAIR   = 4'hC;
  localparam logic [TAG_W-1:0] TAG_SKIP   = 4'hB;

  typedef enum logic [2:0] {
    K_PLAIN  = 3'd0,
    K_PAIR   = 3'd1,
    K_JUMP   = 3'd2,
    K_BRANCH = 3'd3,
    K_SKIP   = 3'd4,
    K_ORPHAN = 3'd5
  } kind_e;
endpackage

// File: rtl/wpf_classify.sv
module wpf_classify
  import wpf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output kind_e             cls,
  output logic              first_of_two
);
  logic [TAG_W-1:0] tag;
  assign tag = word[WORD_W-1 -: TAG_W];

  always_comb begin
    case (tag)
      TAG_CONT:   cls = K_ORPHAN;
      TAG_JUMP:   cls = K_JUMP;
      TAG_BRANCH: cls = K_BRANCH;
      TAG_PAIR:   cls = K_PAIR;
      TAG_SKIP:   cls = K_SKIP;
      default:    cls = K_PLAIN;
    endcase
  end

  assign first_of_two = (cls == K_PAIR) || (cls == K_JUMP);
endmodule

// File: rtl/wpf_pc_ctl.sv
module wpf_pc_ctl
  import wpf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redir,
  input  logic [PC_W-1:0] tgt,
  output logic [PC_W-1:0] pc,
  output logic            issue,
  output logic            rd_vld
);
  logic [PC_W-1:0] pc_n;
  logic            issue_n;
  logic            rd_vld_n;

  always_comb begin
    pc_n     = pc;
    issue_n  = 1'b1;
    rd_vld_n = issue & ~redir;
    if (redir)
      pc_n = tgt;
    else if (issue)
      pc_n = pc + PC_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      issue  <= 1'b0;
      rd_vld <= 1'b0;
    end else begin
      pc     <= pc_n;
      issue  <= issue_n;
      rd_vld <= rd_vld_n;
    end
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && $past(issue) && !$past(redir)) |-> (pc == $past(pc) + PC_W'(2)));

  a_r8_target: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> (pc == $past(tgt)));

  a_r8_squash: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> !rd_vld);

  a_r2_even: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (pc[0] == 1'b0));
endmodule

// File: rtl/wpf_assemble.sv
module wpf_assemble
  import wpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_vld,
  input  logic [WORD_W-1:0] word,
  input  logic [PC_W-1:0]   pc,
  input  logic              skip_cond,
  output logic              ins_vld,
  output kind_e             ins_kind,
  output logic [WORD_W-1:0] ins_word,
  output logic [LIT_W-1:0]  ins_lit,
  output logic [PC_W-1:0]   ins_addr,
  output logic              redir,
  output logic [PC_W-1:0]   tgt
);
  kind_e             cls;
  logic              first_of_two;
  logic              pend, pend_n;
  logic              skip_pend, skip_n;
  logic [WORD_W-1:0] w1, w1_n;
  logic [PC_W-1:0]   w1_addr, w1a_n;
  logic [PC_W-1:0]   here;
  logic              w1_load;

  wpf_classify u_cls (
    .word         (word),
    .cls          (cls),
    .first_of_two (first_of_two)
  );

  assign here = pc - PC_W'(2);

  always_comb begin
    ins_vld  = 1'b0;
    ins_kind = K_PLAIN;
    ins_word = word;
    ins_lit  = '0;
    ins_addr = here;
    redir    = 1'b0;
    tgt      = pc;
    pend_n   = pend;
    skip_n   = skip_pend;
    w1_load  = 1'b0;
    if (rd_vld) begin
      if (pend) begin
        ins_vld  = 1'b1;
        ins_word = w1;
        ins_lit  = word[LIT_W-1:0];
        ins_addr = w1_addr;
        pend_n   = 1'b0;
        if (w1[WORD_W-1 -: TAG_W] == TAG_JUMP) begin
          ins_kind = K_JUMP;
          redir    = 1'b1;
          tgt      = {w1[JHI_W-1:0], word[LIT_W-1:0], 1'b0};
        end else begin
          ins_kind = K_PAIR;
        end
      end else if (skip_pend) begin
        skip_n = 1'b0;
      end else if (first_of_two) begin
        pend_n  = 1'b1;
        w1_load = 1'b1;
      end else begin
        ins_vld  = 1'b1;
        ins_kind = cls;
        if (cls == K_BRANCH) begin
          redir = 1'b1;
          tgt   = pc + {{JHI_W{word[LIT_W-1]}}, word[LIT_W-1:0], 1'b0};
        end
        if (cls == K_SKIP && skip_cond)
          skip_n = 1'b1;
      end
    end
    if (redir) begin
      pend_n = 1'b0;
      skip_n = 1'b0;
    end
  end

  assign w1_n  = w1_load ? word : w1;
  assign w1a_n = w1_load ? here : w1_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      skip_pend <= 1'b0;
    end else begin
      pend      <= pend_n;
      skip_pend <= skip_n;
    end
  end

  always_ff @(posedge clk) begin
    if (w1_load) begin
      w1      <= w1_n;
      w1_addr <= w1a_n;
    end
  end

  a_r4_pend_one: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !pend);

  a_r4_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(!ins_vld));

  a_r5_orphan_form: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && ins_kind == K_ORPHAN) |-> (ins_word[WORD_W-1 -: TAG_W] == TAG_CONT && ins_lit == '0));

  a_r9_skip_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && ins_kind == K_SKIP && skip_cond) |=> (!ins_vld && !redir));
endmodule

// File: rtl/wordpair_fetch.sv
module wordpair_fetch
  import wpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   mem_addr,
  output logic              mem_en,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              skip_cond,
  output logic              ins_vld,
  output logic [2:0]        ins_kind,
  output logic [WORD_W-1:0] ins_word,
  output logic [LIT_W-1:0]  ins_lit,
  output logic [PC_W-1:0]   ins_addr
);
  logic            rs_q1, rs_q2;
  logic            rst_int_n;
  logic            redir;
  logic [PC_W-1:0] tgt;
  logic [PC_W-1:0] pc;
  logic            rd_vld;
  kind_e           kind_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_int_n = rs_q2;

  wpf_pc_ctl u_pc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .redir  (redir),
    .tgt    (tgt),
    .pc     (pc),
    .issue  (mem_en),
    .rd_vld (rd_vld)
  );

  wpf_assemble u_asm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_vld    (rd_vld),
    .word      (mem_rdata),
    .pc        (pc),
    .skip_cond (skip_cond),
    .ins_vld   (ins_vld),
    .ins_kind  (kind_w),
    .ins_word  (ins_word),
    .ins_lit   (ins_lit),
    .ins_addr  (ins_addr),
    .redir     (redir),
    .tgt       (tgt)
  );

  assign mem_addr = pc;
  assign ins_kind = kind_w;

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> (!ins_vld && !mem_en && mem_addr == '0));
endmodule

// File: tb/wordpair_fetch_test.sv
module wordpair_fetch_test;
  logic        clk;
  logic        rst_n;
  logic [20:0] mem_addr;
  logic        mem_en;
  logic [15:0] mem_rdata;
  logic        skip_cond;
  logic        ins_vld;
  logic [2:0]  ins_kind;
  logic [15:0] ins_word;
  logic [11:0] ins_lit;
  logic [20:0] ins_addr;

  logic [15:0] mem [64];

  typedef struct {
    logic [2:0]  kind;
    logic [15:0] word;
    logic [11:0] lit;
    logic [20:0] addr;
    logic        has_tgt;
    logic [20:0] tgt;
    string       req;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  bit   seen_first = 0;
  bit   chk_bubble = 0;
  logic [20:0] bubble_tgt;
  logic [20:0] prev_addr;

  wordpair_fetch uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_en    (mem_en),
    .mem_rdata (mem_rdata),
    .skip_cond (skip_cond),
    .ins_vld   (ins_vld),
    .ins_kind  (ins_kind),
    .ins_word  (ins_word),
    .ins_lit   (ins_lit),
    .ins_addr  (ins_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (mem_en) mem_rdata <= mem[mem_addr[6:1]];

  assign skip_cond = ins_vld & ins_word[0];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] k, input logic [15:0] w, input logic [11:0] l,
                      input logic [20:0] a, input logic ht, input logic [20:0] t,
                      input string r);
    exp_t e;
    e.kind = k; e.word = w; e.lit = l; e.addr = a;
    e.has_tgt = ht; e.tgt = t; e.req = r;
    q.push_back(e);
  endtask

  // monitor: compares each strobe with the next expected item
  initial begin
    prev_addr = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!seen_first && mem_en) begin
          check(mem_addr == 21'd0, "R1", "first fetch address", 32'(mem_addr), 32'd0);
          seen_first = 1;
        end
        if (chk_bubble) begin
          check(!ins_vld, "R8", "bubble after redirect", 32'(ins_vld), 32'd0);
          check(mem_addr == bubble_tgt, "R8", "redirect address", 32'(mem_addr), 32'(bubble_tgt));
          chk_bubble = 0;
        end else if (ins_vld && q.size() > 0) begin
          exp_t e;
          logic [20:0] due;
          e = q.pop_front();
          check(ins_kind == e.kind, e.req, "kind", 32'(ins_kind), 32'(e.kind));
          check(ins_word == e.word, e.req, "word", 32'(ins_word), 32'(e.word));
          check(ins_lit == e.lit, e.req, "literal", 32'(ins_lit), 32'(e.lit));
          check(ins_addr == e.addr, e.req, "address", 32'(ins_addr), 32'(e.addr));
          due = (e.kind == 3'd1 || e.kind == 3'd2) ? prev_addr - 21'd2 : prev_addr;
          check(ins_addr == due, "R3", "latency", 32'(ins_addr), 32'(due));
          if (e.has_tgt) begin
            chk_bubble = 1;
            bubble_tgt = e.tgt;
          end
        end
        prev_addr = mem_addr;
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    mem[0]  = 16'hF010; mem[1]  = 16'h1234; mem[2]  = 16'hC0AB; mem[3]  = 16'hF5CD;
    mem[4]  = 16'hB001; mem[5]  = 16'hE000; mem[6]  = 16'hF777; mem[7]  = 16'hB000;
    mem[8]  = 16'h2222; mem[9]  = 16'hD003; mem[10] = 16'h3333; mem[11] = 16'h6666;
    mem[12] = 16'h6666; mem[13] = 16'hE000; mem[14] = 16'hF018; mem[15] = 16'h4444;
    mem[16] = 16'hDFFF; mem[20] = 16'h5555; mem[21] = 16'hDFE9; mem[24] = 16'hB001;
    mem[25] = 16'hD005; mem[26] = 16'hDFF9; mem[63] = 16'hE000;

    // R5: orphan continuation at reset address
    push(3'd5, 16'hF010, 12'h000, 21'h000000, 0, 21'h0, "R5");
    push(3'd0, 16'h1234, 12'h000, 21'h000002, 0, 21'h0, "R10");
    push(3'd1, 16'hC0AB, 12'h5CD, 21'h000004, 0, 21'h0, "R4");
    // R9: taken skip drops a jump's first word, its second word is an orphan
    push(3'd4, 16'hB001, 12'h000, 21'h000008, 0, 21'h0, "R9");
    push(3'd5, 16'hF777, 12'h000, 21'h00000C, 0, 21'h0, "R9");
    push(3'd4, 16'hB000, 12'h000, 21'h00000E, 0, 21'h0, "R9");
    push(3'd0, 16'h2222, 12'h000, 21'h000010, 0, 21'h0, "R10");
    push(3'd3, 16'hD003, 12'h000, 21'h000012, 1, 21'h00001A, "R7");
    push(3'd2, 16'hE000, 12'h018, 21'h00001A, 1, 21'h000030, "R6");
    // R9: taken skip over a branch leaves the PC alone
    push(3'd4, 16'hB001, 12'h000, 21'h000030, 0, 21'h0, "R9");
    push(3'd3, 16'hDFF9, 12'h000, 21'h000034, 1, 21'h000028, "R7");
    push(3'd0, 16'h5555, 12'h000, 21'h000028, 0, 21'h0, "R10");
    // R2 and R7: branch below zero wraps to the top of the space
    push(3'd3, 16'hDFE9, 12'h000, 21'h00002A, 1, 21'h1FFFFE, "R7");
    push(3'd2, 16'hE000, 12'h010, 21'h1FFFFE, 1, 21'h000020, "R6");
    push(3'd3, 16'hDFFF, 12'h000, 21'h000020, 1, 21'h000020, "R7");
    push(3'd3, 16'hDFFF, 12'h000, 21'h000020, 1, 21'h000020, "R7");

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_addr == 21'd0, "R1", "address in reset", 32'(mem_addr), 32'd0);
    check(!mem_en, "R1", "enable in reset", 32'(mem_en), 32'd0);
    check(!ins_vld, "R1", "strobe in reset", 32'(ins_vld), 32'd0);
    rst_n = 1'b1;

    begin
      int n;
      n = 0;
      while ((q.size() > 0 || chk_bubble) && n < 3000) begin
        @(negedge clk);
        n++;
      end
      if (q.size() > 0 || chk_bubble)
        check(0, "R3", "watchdog, items left", 32'(q.size()), 32'd0);
    end
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule